// File: doc/BRIEF.md
# Interrupt Aggregator with Vectored Priority

This block gathers up to 32 interrupt request lines into a single request to a processor. Each line is fixed at build time as either level-sensitive or edge-sensitive. Captured requests collect in a status register. An enable mask turns that status into a pending set. The block reports the lowest-numbered pending line as a vector code.

Software reaches the block through a small word-addressed register window. It uses a write strobe, a read strobe, a word address and 32-bit data. Reads are combinational and valid in the cycle the read strobe is high.

Enable bits can be changed as a whole word, or through set-only and clear-only aliases. Status bits are cleared with a write-one-to-clear acknowledge. A two-bit master control separately gates the capture of inputs and the outgoing request.

Top module: `irq_hub`

## Requirements
- R1: After a synchronous active-low reset, status, enable, master control and the edge history are zero and `irq_o` is low. The vector therefore reads 32'hFFFF_FFFF.
- R2: The word offsets are decoded as follows: 0 status, 1 pending, 2 enable, 3 acknowledge, 4 enable-set, 5 enable-clear, 6 vector, 7 master control.
  - Offsets 3, 4 and 5 read as zero.
  - Offsets 8 and above read as zero, and writes to them change nothing.
  - `rd_data` is zero whenever `rd_en` is low.
- R3: Reading offset 1 returns the bitwise AND of status and enable, reflecting the current register contents.
- R4: Offset 6 reads the index of the lowest-numbered set pending bit. When nothing is pending it reads 32'hFFFF_FFFF.
- R5: `irq_o` is high exactly when master bit 0 and master bit 1 are both set and at least one pending bit is set.
- R6: A write to offset 3 clears every status bit whose data bit is 1 at the next clock edge, unless the input re-captures that bit.
- R7: A write to offset 4 ORs the data into enable. A write to offset 5 clears the enable bits that are 1 in the data.
- R8: With master bit 1 set, a level-type line (kind bit 0) sets its status bit to the input level sampled at each clock edge. An acknowledge while the line is high therefore has no lasting effect.
- R9: With master bit 1 set, a rising edge on an edge-type line (kind bit 1) sets its status bit. The bit then stays set after the line falls, until it is acknowledged or overwritten.
- R10: While master bit 1 is clear, no input activity changes status.
- R11: If an edge capture and an acknowledge of the same bit fall in the same cycle, the bit ends up set.
- R12: Writes to offsets 0, 2 and 7 store the data directly.
  - Master control keeps only data bits 1:0, and reads return them zero-extended.
  - Writes to offsets 1 and 6 leave no trace.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_i | input | NUM_SRC | Interrupt request lines, synchronous to clk |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Word offset |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data, combinational |
| irq_o | output | 1 | Request to the processor |

## Verification
The assertions assume that `src_i` is already synchronous to `clk`. They also assume that a register write and an input change seen in the same cycle are both meant to take effect at the next edge.

The stimulus drives every input on the falling edge, so each line is stable for a full cycle around the capturing edge. Acknowledge-based assertions only claim a cleared bit while capture is off, since an active level line may legally re-set its bit. The random phase keeps the master control mostly enabled so that capture and acknowledge interleave often.

// File: rtl/irq_hub_pkg.sv
// Package: shared offsets and widths of the interrupt aggregator.
// Assumes the register window decodes eight word offsets.
package irq_hub_pkg;
    typedef enum logic [2:0] {
        OFF_STATUS = 3'd0,
        OFF_PEND   = 3'd1,
        OFF_ENABLE = 3'd2,
        OFF_ACK    = 3'd3,
        OFF_SETEN  = 3'd4,
        OFF_CLREN  = 3'd5,
        OFF_VECTOR = 3'd6,
        OFF_MASTER = 3'd7
    } reg_off_e;

    localparam int MASTER_W = 2;
endpackage

// File: rtl/irq_hub_capture.sv
// Module: per-line capture of interrupt requests into the status register.
// Each line is built as level-following or edge-sticky from KIND_EDGE.
// Assumes src_i is synchronous and wr_status/wr_ack are never both high.
module irq_hub_capture #(
    parameter int               N         = 32,
    parameter logic [N-1:0]     KIND_EDGE = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src_i,
    input  logic         cap_en,
    input  logic         wr_status,
    input  logic         wr_ack,
    input  logic [N-1:0] wr_data,
    output logic [N-1:0] status_q
);
    logic [N-1:0] src_prev_q;
    logic [N-1:0] status_d;

    // Purpose: keep last cycle's input levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) src_prev_q <= '0;
        else        src_prev_q <= src_i;
    end

    for (genvar i = 0; i < N; i++) begin : g_bit
        logic sw_val;
        // Purpose: bus-side effect on this status bit.
        always_comb begin
            if (wr_status)                 sw_val = wr_data[i];
            else if (wr_ack && wr_data[i]) sw_val = 1'b0;
            else                           sw_val = status_q[i];
        end
        if (KIND_EDGE[i]) begin : g_edge
            // Purpose: a rising edge sets the bit and wins over any acknowledge.
            assign status_d[i] = (cap_en && src_i[i] && !src_prev_q[i]) ? 1'b1 : sw_val;

            p_edge_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (status_q[i] && !wr_status && !wr_ack) |=> status_q[i]);
            p_edge_beats_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
                (cap_en && src_i[i] && !src_prev_q[i]) |=> status_q[i]);
        end else begin : g_level
            // Purpose: the bit follows the line while capture is on.
            assign status_d[i] = cap_en ? src_i[i] : sw_val;

            p_level_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
                cap_en |=> (status_q[i] == $past(src_i[i])));
        end
    end

    // Purpose: status register update.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= status_d;
    end

    p_no_capture_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_en && !wr_status && !wr_ack) |=> $stable(status_q));
endmodule

// File: rtl/irq_hub_prio.sv
// Module: lowest-index priority encoder over the pending set.
// Assumes N >= 2; idx_o is meaningful only when any_o is high.
module irq_hub_prio #(
    parameter int N     = 32,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     pend_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);
    // Purpose: scan from the top so the lowest set index is left last.
    always_comb begin
        any_o = |pend_i;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend_i[i]) idx_o = IDX_W'(i);
        end
    end
endmodule

// File: rtl/irq_hub.sv
// Module: interrupt aggregator top with the register window.
// Holds enable and master control, owns decode and read mux, and derives
// pending, vector and the processor request. Assumes NUM_SRC <= DATA_W
// and inputs synchronous to clk.
module irq_hub
    import irq_hub_pkg::*;
#(
    parameter int                 NUM_SRC   = 32,
    parameter int                 DATA_W    = 32,
    parameter int                 ADDR_W    = 4,
    parameter logic [NUM_SRC-1:0] KIND_EDGE = 32'hFFFF_0000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wr_data,
    output logic [DATA_W-1:0]  rd_data,
    output logic               irq_o
);
    localparam int IDX_W = $clog2(NUM_SRC);

    logic                in_map;
    reg_off_e            off;
    logic                wr_hit;
    logic [NUM_SRC-1:0]  wdat;
    logic [NUM_SRC-1:0]  status_q;
    logic [NUM_SRC-1:0]  en_q;
    logic [MASTER_W-1:0] mer_q;
    logic [NUM_SRC-1:0]  pend;
    logic                pend_any;
    logic [IDX_W-1:0]    pend_idx;
    logic [DATA_W-1:0]   vector;

    // Purpose: decode whether the address lands in the eight-word window.
    assign in_map = (addr >> 3) == '0;
    assign off    = reg_off_e'(addr[2:0]);
    assign wr_hit = wr_en && in_map;
    assign wdat   = wr_data[NUM_SRC-1:0];

    irq_hub_capture #(
        .N         (NUM_SRC),
        .KIND_EDGE (KIND_EDGE)
    ) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_i     (src_i),
        .cap_en    (mer_q[1]),
        .wr_status (wr_hit && off == OFF_STATUS),
        .wr_ack    (wr_hit && off == OFF_ACK),
        .wr_data   (wdat),
        .status_q  (status_q)
    );

    // Purpose: enable register with whole-word, set and clear writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (wr_hit) begin
            case (off)
                OFF_ENABLE: en_q <= wdat;
                OFF_SETEN:  en_q <= en_q | wdat;
                OFF_CLREN:  en_q <= en_q & ~wdat;
                default:    en_q <= en_q;
            endcase
        end
    end

    // Purpose: master control register, low two bits only.
    always_ff @(posedge clk) begin
        if (!rst_n)                           mer_q <= '0;
        else if (wr_hit && off == OFF_MASTER) mer_q <= wr_data[MASTER_W-1:0];
    end

    assign pend = status_q & en_q;

    irq_hub_prio #(
        .N     (NUM_SRC),
        .IDX_W (IDX_W)
    ) u_prio (
        .pend_i (pend),
        .any_o  (pend_any),
        .idx_o  (pend_idx)
    );

    // Purpose: vector code, all ones when nothing pends.
    assign vector = pend_any ? DATA_W'(pend_idx) : '1;

    // Purpose: processor request gated by both master bits.
    assign irq_o = mer_q[0] && mer_q[1] && pend_any;

    // Purpose: combinational read mux.
    always_comb begin
        rd_data = '0;
        if (rd_en && in_map) begin
            case (off)
                OFF_STATUS: rd_data = DATA_W'(status_q);
                OFF_PEND:   rd_data = DATA_W'(pend);
                OFF_ENABLE: rd_data = DATA_W'(en_q);
                OFF_VECTOR: rd_data = vector;
                OFF_MASTER: rd_data = DATA_W'(mer_q);
                default:    rd_data = '0;
            endcase
        end
    end

    p_vector_lowest_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pend != '0) |-> (pend[pend_idx] &&
            ((pend & ((NUM_SRC'(1) << pend_idx) - NUM_SRC'(1))) == '0)));
    p_irq_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !mer_q[1] |-> !irq_o);
    p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && off == OFF_ACK && !mer_q[1]) |=> ((status_q & $past(wdat)) == '0));
    p_set_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && off == OFF_SETEN) |=> ((en_q & $past(wdat)) == $past(wdat)));
    p_clear_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && off == OFF_CLREN) |=> ((en_q & $past(wdat)) == '0));
    p_ignore_outside_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !in_map) |=> ($stable(en_q) && $stable(mer_q)));
endmodule

// File: tb/irq_hub_tb.sv
// Bench: behavioural reference model of the aggregator, compared every cycle.
module irq_hub_tb;
    localparam logic [31:0] KIND = 32'hFFFF_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq_o;

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;

    // Reference state.
    logic [31:0] m_st = '0, m_en = '0, m_prev = '0;
    logic [1:0]  m_mer = '0;

    always #2 clk = ~clk;

    irq_hub #(.KIND_EDGE(KIND)) u_dut (
        .clk(clk), .rst_n(rst_n), .src_i(src), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq_o(irq_o)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    function automatic logic [31:0] m_vector();
        logic [31:0] p = m_st & m_en;
        for (int i = 0; i < 32; i++) if (p[i]) return i;
        return 32'hFFFF_FFFF;
    endfunction

    function automatic logic [31:0] m_read(input int a);
        case (a)
            0: return m_st;
            1: return m_st & m_en;
            2: return m_en;
            6: return m_vector();
            7: return {30'b0, m_mer};
            default: return 32'h0;
        endcase
    endfunction

    task automatic m_advance(input bit w, input int a, input logic [31:0] d, input logic [31:0] s);
        logic [31:0] st_n, en_n;
        logic [1:0]  mer_n;
        if (!rst_n) begin
            m_st = '0; m_en = '0; m_mer = '0; m_prev = '0;
            return;
        end
        st_n = m_st; en_n = m_en; mer_n = m_mer;
        if (w) begin
            if (a == 0) st_n = d;
            if (a == 3) st_n = m_st & ~d;
            if (a == 2) en_n = d;
            if (a == 4) en_n = m_en | d;
            if (a == 5) en_n = m_en & ~d;
            if (a == 7) mer_n = d[1:0];
        end
        if (m_mer[1]) begin
            for (int i = 0; i < 32; i++) begin
                if (!KIND[i]) st_n[i] = s[i];
                else if (s[i] && !m_prev[i]) st_n[i] = 1'b1;
            end
        end
        m_st = st_n; m_en = en_n; m_mer = mer_n; m_prev = s;
    endtask

    task automatic step(input bit w, input bit r, input int a, input logic [31:0] d,
                        input logic [31:0] s, input string tag);
        @(negedge clk);
        wr_en = w; rd_en = r; addr = a[3:0]; wr_data = d; src = s;
        #1;
        check({31'b0, irq_o}, {31'b0, m_mer[0] & m_mer[1] & ((m_st & m_en) != 0)}, "R5 irq");
        if (r) check(rd_data, m_read(a), tag);
        else   check(rd_data, 32'h0, "R2 idle read");
        m_advance(w, a, d, s);
    endtask

    task automatic rd(input int a, input logic [31:0] s, input string tag);
        step(1'b0, 1'b1, a, 32'h0, s, tag);
    endtask

    task automatic wr(input int a, input logic [31:0] d, input logic [31:0] s, input string tag);
        step(1'b1, 1'b0, a, d, s, tag);
    endtask

    // Watchdog: a hung run is a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        // R1: reset values, vector all ones.
        for (int a = 0; a < 10; a++) rd(a, '0, "R1 reset read");
        rst_n = 1'b1;
        for (int a = 0; a < 10; a++) rd(a, '0, "R1 after reset");

        // R12: master stores only bits 1:0.
        wr(7, 32'hFFFF_FFFF, '0, "R12");
        rd(7, '0, "R12 master read");
        wr(4, 32'h0003_0003, '0, "R7");
        rd(2, '0, "R7 set enable");

        // R8: level line follows input.
        rd(0, 32'h1, "R8");
        rd(0, 32'h1, "R8 level high");
        rd(6, 32'h1, "R4 vector 0");
        wr(3, 32'h1, 32'h1, "R8");
        rd(0, 32'h1, "R8 ack while high");
        rd(0, 32'h0, "R8 low");
        rd(0, 32'h0, "R8 level cleared");
        rd(6, 32'h0, "R4 vector none");

        // R9: edge line sticky.
        rd(0, 32'h0001_0000, "R9");
        rd(0, 32'h0, "R9 sticky");
        rd(6, 32'h0, "R4 vector 16");
        rd(1, 32'h0, "R3 pending");
        wr(3, 32'h0001_0000, 32'h0, "R6");
        rd(0, 32'h0, "R6 ack cleared");

        // R11: edge and acknowledge in the same cycle.
        wr(3, 32'h0002_0000, 32'h0002_0000, "R11");
        rd(0, 32'h0002_0000, "R11 edge wins");
        wr(3, 32'h0002_0000, 32'h0, "R6");
        rd(0, 32'h0, "R6");

        // R5: bit 0 clear masks the request.
        rd(0, 32'h0001_0000, "R5");
        wr(7, 32'h2, 32'h0, "R5");
        rd(1, 32'h0, "R5 pending no irq");
        wr(7, 32'h3, 32'h0, "R5");
        rd(6, 32'h0, "R4");

        // R10: capture off.
        wr(7, 32'h1, 32'h0, "R10");
        rd(0, 32'h0000_0003, "R10");
        rd(0, 32'h0002_0003, "R10 no capture");
        rd(0, 32'h0, "R10 no capture");

        // R7: clear enable.
        wr(5, 32'h0001_0000, 32'h0, "R7");
        rd(2, 32'h0, "R7 clear enable");
        rd(1, 32'h0, "R3 after clear");

        // R12 / R2: direct and ignored writes.
        wr(0, 32'h0000_0C02, 32'h0, "R12");
        rd(0, 32'h0, "R12 status write");
        wr(2, 32'h0000_0800, 32'h0, "R12");
        rd(6, 32'h0, "R4 vector 11");
        wr(1, 32'hFFFF_FFFF, 32'h0, "R12");
        wr(6, 32'h0, 32'h0, "R12");
        rd(1, 32'h0, "R12 pending write ignored");
        wr(9, 32'hFFFF_FFFF, 32'h0, "R2");
        rd(2, 32'h0, "R2 outside write ignored");
        rd(7, 32'h0, "R2 master after outside write");
        rd(3, 32'h0, "R2 ack reads zero");
        rd(4, 32'h0, "R2 set reads zero");
        rd(15, 32'h0, "R2 outside reads zero");

        // Mixed traffic.
        wr(7, 32'h3, 32'h0, "R5");
        for (int k = 0; k < 600; k++) begin
            int a;
            logic [31:0] d;
            logic [31:0] s;
            a = $urandom % 10;
            d = $urandom;
            if (a == 7 && ($urandom % 4 != 0)) d = 32'h3;
            s = src ^ ($urandom & $urandom & $urandom);
            step(($urandom % 3) == 0, 1'b1, a, d, s,
                 (a == 1) ? "R3 mixed" : (a == 6) ? "R4 mixed" :
                 (a == 0) ? "R8 R9 mixed" : (a == 2) ? "R7 mixed" : "R2 mixed");
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule